// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the scan timing for a text display made of character cells. A scan line has 64 character slots, and each slot lasts a fixed number of bit-time clocks. The slot number is split into two octal digits. Two three-bit digit decoders produce one-hot codes, and each timing event is taken from one pair of those codes. Horizontal sync starts at slot 56 and ends when the count wraps at slot 64. The display-active flag covers the slots from 0 up to a configured last visible slot.

Four static configuration inputs set the page height, which can be 1 to 16 text lines. The line counter keeps its lowest bit in a separate toggle flip-flop, so odd heights need no extra logic. After the last text line, an end-of-page pulse starts vertical retrace. A retrace counter advances once per line, steered by slot 62 at fixed bit times. It ends retrace after a constant number of line periods, so the vertical retrace time is the same for every page height. A free-running prescaler toggles a supply-drive enable at a fixed rate (19.2 kHz from a 125 MHz clock by default).

The block has no data stream: all pins are plain control and timing signals, and there is no handshake. Every output is a flip-flop. Each output reflects the counter state of the previous clock.

Top module: `cell_raster_timer`

## Requirements
- R1: A synchronous reset (`rst` high) drives every output low. It clears the bit-time, slot, line and retrace counters and the steering and toggle flip-flops, and it loads the page height from `cfg_lines`.
- R2: Each character slot lasts BT_PER_SLOT clocks (default 8). The slot count runs 0 to 63 and wraps, so a scan line lasts 64*BT_PER_SLOT clocks.
- R3: `hsync_o` goes high one clock after the counter enters slot 56 at bit time 0. It goes low one clock after the count wraps to slot 0, so it is high for slots 56 to 63 only.
- R4: `disp_o` is high, with one clock of lag, exactly when the block is outside vertical retrace and the current slot is less than or equal to `cfg_last_slot`, which is an unsigned 6-bit slot number.
- R5: A page has `cfg_lines` text lines, where the value 0 means 16. The lowest bit of the line index is a toggle flip-flop that flips at each line end, so odd heights work the same way as even ones.
- R6: `eop_o` is a single-clock pulse, one clock after bit time 0 of slot 0 of the first retrace line. It coincides with the rising edge of `vsync_o`.
- R7: `vsync_o` stays high for exactly VR_LINES line periods (default 4), whatever the page height. Each retrace line advances the retrace counter once: the count is armed at bit time 4 of slot 62 and advances at the last bit time of that slot.
- R8: `cfg_lines` is sampled only during reset and at the end of vertical retrace. A change in the middle of a page does not alter the current page.
- R9: `hv_en_o` toggles every HV_HALF clocks (default 3255), starting low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lines | input | 4 | Static page height in text lines (0 means 16) |
| cfg_last_slot | input | 6 | Static number of the last visible character slot |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync (vertical retrace interval) |
| disp_o | output | 1 | Display-active flag |
| eop_o | output | 1 | End-of-page pulse, one clock |
| hv_en_o | output | 1 | Fixed-rate supply-drive enable |

## Verification
Embedded properties check the following on every clock:
- the slot count advances at the last bit time;
- the retrace counter never passes its terminal count;
- the line toggle flips when a text line ends;
- the drive enable changes only at prescaler terminal;
- `eop_o` is a lone pulse that lies inside `vsync_o`;
- display-active is never high during vertical sync.

Only the bench scenarios show the rest, by comparing every output cycle by cycle with a model built from the requirements:
- the page height for the values 0, 1, odd and even, and random ones;
- that the retrace length does not depend on the height;
- that a height change in mid-page is postponed;
- that the visible-slot limit is obeyed.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
  localparam int DIGIT_W = 3;
  localparam int SLOT_W  = 2 * DIGIT_W;
  localparam int DIGITS  = 1 << DIGIT_W;
  localparam int LINE_W  = 4;

  typedef struct packed {
    logic hs_set;
    logic hs_clr;
    logic steer_arm;
    logic steer_fire;
    logic line_end;
  } slot_events_t;

  function automatic logic [LINE_W-1:0] last_index(input logic [LINE_W-1:0] height);
    return height - LINE_W'(1);
  endfunction
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import crt_timing_pkg::*;
#(
  parameter int BT_PER_SLOT = 8,
  parameter int HS_ON_SLOT  = 56,
  parameter int STEER_SLOT  = 62,
  parameter int STEER_ARM_BT = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot_o,
  output slot_events_t      ev_o
);
  localparam int BT_W = (BT_PER_SLOT > 1) ? $clog2(BT_PER_SLOT) : 1;
  localparam logic [BT_W-1:0] BT_LAST = BT_W'(BT_PER_SLOT - 1);
  localparam int LAST_SLOT = (1 << SLOT_W) - 1;

  logic [BT_W-1:0]   bt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DIGITS-1:0] hi_oh, lo_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bt_q   <= '0;
      slot_q <= '0;
    end else if (bt_q == BT_LAST) begin
      bt_q   <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else begin
      bt_q <= bt_q + BT_W'(1);
    end
  end

  // two octal digit decoders, one per digit of the slot count
  for (genvar d = 0; d < DIGITS; d++) begin : g_oct
    assign hi_oh[d] = (slot_q[SLOT_W-1:DIGIT_W] == DIGIT_W'(d));
    assign lo_oh[d] = (slot_q[DIGIT_W-1:0] == DIGIT_W'(d));
  end

  function automatic logic slot_is(input int n);
    return hi_oh[n / DIGITS] & lo_oh[n % DIGITS];
  endfunction

  always_comb begin
    ev_o.hs_set     = slot_is(HS_ON_SLOT) && (bt_q == '0);
    ev_o.hs_clr     = slot_is(0) && (bt_q == '0);
    ev_o.steer_arm  = slot_is(STEER_SLOT) && (bt_q == BT_W'(STEER_ARM_BT));
    ev_o.steer_fire = (bt_q == BT_LAST);
    ev_o.line_end   = slot_is(LAST_SLOT) && (bt_q == BT_LAST);
  end

  assign slot_o = slot_q;

  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    (bt_q == BT_LAST) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bt_q != BT_LAST) |=> $stable(slot_q));
endmodule

// File: rtl/page_sequencer.sv
module page_sequencer
  import crt_timing_pkg::*;
#(
  parameter int VR_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] cfg_lines,
  input  slot_events_t      ev_i,
  output logic              retrace_o,
  output logic              page_end_o
);
  localparam int VR_W = $clog2(VR_LINES + 1);
  localparam logic [VR_W-1:0] VR_TERM = VR_W'(VR_LINES);

  logic [LINE_W-2:0] pair_q;
  logic              tog_q;
  logic [LINE_W-1:0] height_q;
  logic              vr_q, steer_q;
  logic [VR_W-1:0]   vrc_q;
  logic [LINE_W-1:0] idx;

  assign idx = {pair_q, tog_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q   <= '0;
      tog_q    <= 1'b0;
      height_q <= cfg_lines;
      vr_q     <= 1'b0;
      steer_q  <= 1'b0;
      vrc_q    <= '0;
    end else begin
      if (ev_i.steer_arm && vr_q) steer_q <= 1'b1;
      if (ev_i.steer_fire && steer_q) begin
        steer_q <= 1'b0;
        vrc_q   <= vrc_q + VR_W'(1);
      end
      if (ev_i.line_end) begin
        if (!vr_q) begin
          if (idx == last_index(height_q)) begin
            vr_q  <= 1'b1;
            vrc_q <= '0;
          end else begin
            tog_q <= ~tog_q;
            if (tog_q) pair_q <= pair_q + (LINE_W-1)'(1);
          end
        end else if (vrc_q == VR_TERM) begin
          vr_q     <= 1'b0;
          vrc_q    <= '0;
          pair_q   <= '0;
          tog_q    <= 1'b0;
          height_q <= cfg_lines;
        end
      end
    end
  end

  assign retrace_o  = vr_q;
  assign page_end_o = vr_q && (vrc_q == '0) && ev_i.hs_clr;

  p_retrace_cap_r7: assert property (@(posedge clk) disable iff (rst)
    vrc_q <= VR_TERM);
  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_i.line_end && !vr_q && idx != last_index(height_q)) |=> (tog_q != $past(tog_q)));
  p_height_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(ev_i.line_end && vr_q) |=> $stable(height_q));
endmodule

// File: rtl/drive_prescaler.sv
module drive_prescaler #(
  parameter int HV_HALF = 3255
) (
  input  logic clk,
  input  logic rst,
  output logic en_o
);
  localparam int CNT_W = (HV_HALF > 1) ? $clog2(HV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      en_q  <= ~en_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o = en_q;

  p_toggle_at_term_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q != $past(en_q)) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/cell_raster_timer.sv
module cell_raster_timer
  import crt_timing_pkg::*;
#(
  parameter int BT_PER_SLOT = 8,
  parameter int VR_LINES    = 4,
  parameter int HV_HALF     = 3255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cfg_lines,
  input  logic [5:0] cfg_last_slot,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       disp_o,
  output logic       eop_o,
  output logic       hv_en_o
);
  logic [SLOT_W-1:0] slot;
  slot_events_t      ev;
  logic              retrace, page_end;

  slot_sequencer #(.BT_PER_SLOT(BT_PER_SLOT)) u_slot (
    .clk(clk), .rst(rst), .slot_o(slot), .ev_o(ev)
  );

  page_sequencer #(.VR_LINES(VR_LINES)) u_page (
    .clk(clk), .rst(rst), .cfg_lines(cfg_lines), .ev_i(ev),
    .retrace_o(retrace), .page_end_o(page_end)
  );

  drive_prescaler #(.HV_HALF(HV_HALF)) u_drive (
    .clk(clk), .rst(rst), .en_o(hv_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      disp_o  <= 1'b0;
      eop_o   <= 1'b0;
    end else begin
      if (ev.hs_set)      hsync_o <= 1'b1;
      else if (ev.hs_clr) hsync_o <= 1'b0;
      vsync_o <= retrace;
      disp_o  <= !retrace && (slot <= cfg_last_slot);
      eop_o   <= page_end;
    end
  end

  p_eop_single_r6: assert property (@(posedge clk) disable iff (rst)
    eop_o |=> !eop_o);
  p_eop_in_vsync_r6: assert property (@(posedge clk) disable iff (rst)
    eop_o |-> vsync_o);
  p_dark_in_vsync_r4: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> !disp_o);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(hsync_o || vsync_o || disp_o || eop_o));
endmodule

// File: tb/cell_raster_timer_bench.sv
module cell_raster_timer_bench;
  localparam int BT = 8;
  localparam int VR = 4;
  localparam int HALF = 3255;
  localparam int LINE_CLKS = 64 * BT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cfg_lines = 4'd0;
  logic [5:0] cfg_last_slot = 6'd39;
  logic hsync_o, vsync_o, disp_o, eop_o, hv_en_o;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cell_raster_timer u_cell_raster_timer (
    .clk(clk), .rst(rst), .cfg_lines(cfg_lines), .cfg_last_slot(cfg_last_slot),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_o(disp_o), .eop_o(eop_o), .hv_en_o(hv_en_o)
  );

  function automatic int height_of(input logic [3:0] c);
    return (c == 4'd0) ? 16 : int'(c);
  endfunction

  // reference model built from the requirements
  int m_k = 0, m_line = 0, m_lines = 16, m_hv = 0;
  logic e_hs = 0, e_vs = 0, e_disp = 0, e_eop = 0, e_hv = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_k = 0; m_line = 0; m_lines = height_of(cfg_lines); m_hv = 0;
      e_hs = 0; e_vs = 0; e_disp = 0; e_eop = 0; e_hv = 0;
    end else begin
      e_hs   = (m_k / BT) >= 56;
      e_vs   = m_line >= m_lines;
      e_disp = !e_vs && ((m_k / BT) <= int'(cfg_last_slot));
      e_eop  = (m_line == m_lines) && (m_k == 0);
      m_k++;
      if (m_k == LINE_CLKS) begin
        m_k = 0; m_line++;
        if (m_line == m_lines + VR) begin
          m_line = 0; m_lines = height_of(cfg_lines);
        end
      end
      if (m_hv == HALF - 1) begin m_hv = 0; e_hv = !e_hv; end
      else m_hv++;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, sampled away from the active edge
  int vs_run = 0, hv_last = 0, cyc = 0;
  logic hv_prev = 0, vs_prev = 0, first_hv = 1;
  always @(negedge clk) begin
    cyc++;
    chk(hsync_o, e_hs,   "R3 hsync");
    chk(vsync_o, e_vs,   "R7 vsync");
    chk(disp_o,  e_disp, "R4 disp");
    chk(eop_o,   e_eop,  "R6 eop");
    chk(hv_en_o, e_hv,   "R9 hv_en");
    if (!rst) begin
      if (vsync_o) vs_run++;
      if (vs_prev && !vsync_o) begin
        chk_int(vs_run, VR * LINE_CLKS, "R7 vsync length");
        vs_run = 0;
      end
      if (eop_o) chk(vsync_o, 1'b1, "R6 eop inside vsync");
      if (hv_en_o != hv_prev) begin
        if (!first_hv) chk_int(cyc - hv_last, HALF, "R9 hv period");
        first_hv = 0; hv_last = cyc;
      end
    end else begin
      vs_run = 0; first_hv = 1;
    end
    hv_prev = hv_en_o; vs_prev = vsync_o;
  end

  // R5 page height: measure clocks between end-of-page pulses
  int last_eop = -1;
  always @(negedge clk) begin
    if (rst) last_eop = -1;
    else if (eop_o) last_eop = cyc;
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    wait_clks(3);
    chk(hsync_o | vsync_o | disp_o | eop_o | hv_en_o, 1'b0, "R1 outputs low in reset");
    rst = 1'b0;
    // directed heights: 16 (code 0), 1, odd 5, even 4, 15
    begin
      logic [3:0] dir [5] = '{4'd0, 4'd1, 4'd5, 4'd4, 4'd15};
      for (int i = 0; i < 5; i++) begin
        cfg_lines = dir[i];
        cfg_last_slot = (i == 1) ? 6'd63 : ((i == 2) ? 6'd0 : 6'(20 + 7 * i));
        wait_clks((height_of(dir[i]) + VR) * LINE_CLKS + 1000);
        chk(last_eop >= 0, 1'b1, "R5 end of page seen");
      end
    end
    // R8: mid-page change must wait for the end of retrace (model enforces timing)
    for (int i = 0; i < 9; i++) begin
      cfg_lines = 4'($urandom_range(0, 15));
      cfg_last_slot = 6'($urandom_range(0, 63));
      wait_clks($urandom_range(3000, 11000));
    end
    // R1: mid-run reset
    rst = 1'b1;
    wait_clks(2);
    chk(hsync_o | vsync_o | disp_o | eop_o | hv_en_o, 1'b0, "R1 reset mid-run");
    rst = 1'b0;
    cfg_lines = 4'd3;
    wait_clks(2);
    chk(disp_o, 1'b1, "R4 slot 0 visible after reset");
    chk(hsync_o, 1'b0, "R3 hsync low at line start");
    wait_clks(57 * BT);
    chk(hsync_o, 1'b1, "R2 R3 hsync high by slot 57");
    wait_clks(8000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule